// File: doc/BRIEF.md
# Serial Audio Word-Rate Interrupt Generator

This block is the timing core of a two-channel serial audio port. It holds an 8-bit clock divider N and a small mode register. In master mode it derives a bit clock and a word strobe from the system clock and raises a one-cycle interrupt at the start of every audio word. In slave mode it watches a word strobe arriving from outside. It passes that strobe through a synchroniser and turns the strobe edges chosen by the mode register into one-cycle interrupt pulses.

Software, or a neighbouring sequencer, writes the divider and the mode through two write strobes. The interrupt pulse goes to the audio processor's interrupt logic. The status output gives the current strobe level and whether that level marks the left channel. Shifting of sample data is not part of this block.

Top module: `serial_word_rate_gen`

## Requirements
- R1: After reset the divider holds 8 and the mode register holds 0 (slave mode). `irqOut`, `bitClkOut` and `wordStrobeOut` are 0, and `wsStatus` is 2'b10.
- R2: A divider write restarts the period timer in the clock edge that takes the write. In master mode the next interrupt comes exactly 64*(N+1) cycles after that edge, where N is the new value. No interrupt is raised in the cycle that follows the write.
- R3: In master mode (mode bit 0 = 1) `irqOut` is a single-cycle pulse that repeats every 64*(N+1) system cycles.
- R4: In master mode `bitClkOut` starts low after a restart and toggles every N+1 cycles. In slave mode it is held low.
- R5: The internal word strobe starts at 0 after reset and toggles with every master-mode interrupt, which is every 32 bit-clock periods. `wordStrobeOut` shows it only while mode bit 0 and mode bit 1 (strobe output enable) are both 1. Otherwise `wordStrobeOut` is 0.
- R6: A mode write that moves from slave to master mode restarts the period timer, as a divider write does.
- R7: In slave mode with mode bit 2 set, each rising edge on `extStrobe` gives one `irqOut` pulse. The pulse is visible after the third rising clock edge that follows the input change.
- R8: In slave mode with mode bit 3 set, each falling edge on `extStrobe` gives one `irqOut` pulse, with the same latency as R7.
- R9: In slave mode with mode bit 4 set (every word), both edges of `extStrobe` give a pulse, even when the strobe toggles on every cycle.
- R10: In slave mode with mode bits 2, 3 and 4 all clear, `irqOut` stays 0 whatever `extStrobe` does.
- R11: `wsStatus[0]` is the current strobe level: the internal strobe in master mode, the synchronised `extStrobe` in slave mode. `wsStatus[1]` is its inverse (1 = left word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divWrEn | input | 1 | Write strobe for the clock divider |
| divWrData | input | 8 | New divider value N |
| modeWrEn | input | 1 | Write strobe for the mode register |
| modeWrData | input | 5 | Mode: [0] master, [1] strobe output enable, [2] rising, [3] falling, [4] every word |
| extStrobe | input | 1 | Word strobe from an external master (asynchronous) |
| bitClkOut | output | 1 | Generated bit clock |
| wordStrobeOut | output | 1 | Generated word strobe |
| irqOut | output | 1 | One-cycle word-rate interrupt pulse |
| wsStatus | output | 2 | [0] strobe level, [1] left-channel flag |

## Verification
The bench rewrites the divider in the middle of a period and writes the same value twice. A design that failed to restart the timer would put its next pulse at the old phase instead of 64*(N+1) cycles later. With N = 0 the bit clock toggles on every cycle, where an off-by-one in the prescaler shows up at once. In slave mode the strobe is toggled on every cycle and every second cycle under every-word selection. A design that merged edges or lost one in the synchroniser would drop pulses. With no edge bit selected, a design that treated "no selection" as "all edges" would raise spurious interrupts.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  localparam int MODE_W     = 5;
  localparam int MODE_INT   = 0;
  localparam int MODE_WSEN  = 1;
  localparam int MODE_RISE  = 2;
  localparam int MODE_FALL  = 3;
  localparam int MODE_EVERY = 4;

  // control-to-datapath strobes
  typedef struct packed {
    logic intMode;
    logic wsEn;
    logic selRise;
    logic selFall;
    logic selEvery;
    logic bitPhase;
    logic wordTick;
    logic restart;
  } wrStrb_t;
endpackage

// File: rtl/wrg_ctrl.sv
module wrg_ctrl
  import wrg_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 8,
  parameter int HALVES  = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                divWrEn,
  input  logic [DIV_W-1:0]    divWrData,
  input  logic                modeWrEn,
  input  logic [MODE_W-1:0]   modeWrData,
  output wrStrb_t             strb
);
  localparam int HALF_W = $clog2(HALVES);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALVES - 1);

  logic [DIV_W-1:0]  divReg;
  logic [MODE_W-1:0] modeReg;
  logic [DIV_W-1:0]  preCnt;
  logic [HALF_W-1:0] halfCnt;
  logic              preWrap;

  assign preWrap = (preCnt == divReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= DIV_W'(DIV_RST);
      modeReg <= '0;
      preCnt  <= '0;
      halfCnt <= '0;
    end else begin
      if (!modeReg[MODE_INT] || divWrEn) begin
        preCnt  <= '0;
        halfCnt <= '0;
      end else if (preWrap) begin
        preCnt  <= '0;
        halfCnt <= (halfCnt == HALF_LAST) ? '0 : halfCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
      if (divWrEn)  divReg  <= divWrData;
      if (modeWrEn) modeReg <= modeWrData;
    end
  end

  always_comb begin
    strb.intMode  = modeReg[MODE_INT];
    strb.wsEn     = modeReg[MODE_WSEN];
    strb.selRise  = modeReg[MODE_RISE];
    strb.selFall  = modeReg[MODE_FALL];
    strb.selEvery = modeReg[MODE_EVERY];
    strb.bitPhase = halfCnt[0];
    strb.restart  = modeReg[MODE_INT] && divWrEn;
    strb.wordTick = modeReg[MODE_INT] && !divWrEn && preWrap && (halfCnt == HALF_LAST);
  end

  // R3: word ticks never come on back-to-back cycles
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordTick |=> !strb.wordTick);

  // R4: bit clock phase only advances at a prescaler wrap
  p_phase_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[MODE_INT] && !preWrap && !divWrEn) |=> $stable(halfCnt));
endmodule

// File: rtl/wrg_datapath.sv
module wrg_datapath
  import wrg_pkg::*;
#(
  parameter int SYNC_LEN = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  wrStrb_t strb,
  input  logic    extStrobe,
  output logic    bitClkOut,
  output logic    wordStrobeOut,
  output logic    irqOut,
  output logic [1:0] wsStatus
);
  logic [SYNC_LEN:0] syncQ;
  logic              wsReg;
  logic              extNow;
  logic              extPrev;
  logic              slaveHit;
  logic              level;

  assign extNow  = syncQ[SYNC_LEN-1];
  assign extPrev = syncQ[SYNC_LEN];

  always_comb begin
    slaveHit = (extNow && !extPrev && (strb.selRise || strb.selEvery)) ||
               (!extNow && extPrev && (strb.selFall || strb.selEvery));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      wsReg  <= 1'b0;
      irqOut <= 1'b0;
    end else begin
      syncQ  <= {syncQ[SYNC_LEN-1:0], extStrobe};
      wsReg  <= wsReg ^ strb.wordTick;
      irqOut <= strb.intMode ? strb.wordTick : slaveHit;
    end
  end

  assign level         = strb.intMode ? wsReg : extNow;
  assign bitClkOut     = strb.intMode && strb.bitPhase;
  assign wordStrobeOut = strb.intMode && strb.wsEn && wsReg;
  assign wsStatus      = {~level, level};

  // R2: a restart in master mode never produces a pulse
  p_restart_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> !irqOut);

  // R3: master-mode pulses last one cycle
  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && strb.intMode) |=> !irqOut);

  // R5: the strobe level only moves on a word tick
  p_ws_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wordTick |=> $stable(wsReg));

  // R10: no synchronised edge, no slave interrupt
  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.intMode && (extNow == extPrev)) |=> !irqOut);
endmodule

// File: rtl/serial_word_rate_gen.sv
module serial_word_rate_gen
  import wrg_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_RST  = 8,
  parameter int HALVES   = 64,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              divWrEn,
  input  logic [DIV_W-1:0]  divWrData,
  input  logic              modeWrEn,
  input  logic [4:0]        modeWrData,
  input  logic              extStrobe,
  output logic              bitClkOut,
  output logic              wordStrobeOut,
  output logic              irqOut,
  output logic [1:0]        wsStatus
);
  wrStrb_t strb;

  wrg_ctrl #(.DIV_W(DIV_W), .DIV_RST(DIV_RST), .HALVES(HALVES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .divWrEn    (divWrEn),
    .divWrData  (divWrData),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .strb       (strb)
  );

  wrg_datapath #(.SYNC_LEN(SYNC_LEN)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .extStrobe     (extStrobe),
    .bitClkOut     (bitClkOut),
    .wordStrobeOut (wordStrobeOut),
    .irqOut        (irqOut),
    .wsStatus      (wsStatus)
  );
endmodule

// File: tb/serial_word_rate_gen_tb.sv
module serial_word_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       divWrEn = 1'b0;
  logic [7:0] divWrData = '0;
  logic       modeWrEn = 1'b0;
  logic [4:0] modeWrData = '0;
  logic       extStrobe = 1'b0;
  logic       bitClkOut, wordStrobeOut, irqOut;
  logic [1:0] wsStatus;

  int errs = 0;
  int checks = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  string irqTag = "R1";

  // reference model state
  int mDiv = 8;
  int mMode = 0;
  int mCnt = 0;
  int mWs = 0;
  int mS1 = 0, mS2 = 0, mS3 = 0;
  int mIrq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_rate_gen u_dut (
    .clk(clk), .rstN(rstN),
    .divWrEn(divWrEn), .divWrData(divWrData),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .extStrobe(extStrobe),
    .bitClkOut(bitClkOut), .wordStrobeOut(wordStrobeOut),
    .irqOut(irqOut), .wsStatus(wsStatus)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 8; mMode = 0; mCnt = 0; mWs = 0;
      mS1 = 0; mS2 = 0; mS3 = 0; mIrq = 0;
    end else begin
      int period;
      int nIrq;
      bit intm;
      intm   = mMode[0];
      period = 64 * (mDiv + 1);
      nIrq   = 0;
      if (intm && !divWrEn) begin
        mCnt = (mCnt + 1) % period;
        nIrq = (mCnt == 0);
      end else begin
        mCnt = 0;
      end
      if (!intm) begin
        nIrq = ((mS2 == 1) && (mS3 == 0) && (mMode[2] || mMode[4])) ||
               ((mS2 == 0) && (mS3 == 1) && (mMode[3] || mMode[4]));
      end
      if (intm && nIrq != 0) mWs = 1 - mWs;
      mS3 = mS2; mS2 = mS1; mS1 = int'(extStrobe);
      if (divWrEn)  mDiv  = int'(divWrData);
      if (modeWrEn) mMode = int'(modeWrData);
      mIrq = nIrq;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && rstN) begin
      int expBit, expLvl;
      expBit = (mMode[0] && (((mCnt / (mDiv + 1)) % 2) == 1)) ? 1 : 0;
      expLvl = mMode[0] ? mWs : mS2;
      check({irqTag, " irqOut"}, int'(irqOut), mIrq);
      check("R4 bitClkOut", int'(bitClkOut), expBit);
      check("R5 wordStrobeOut", int'(wordStrobeOut), (mMode[0] && mMode[1] && mWs == 1) ? 1 : 0);
      check("R11 wsStatus", int'(wsStatus), ((1 - expLvl) << 1) | expLvl);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrDiv(input int v);
    divWrEn = 1'b1; divWrData = 8'(v);
    @(negedge clk);
    divWrEn = 1'b0;
  endtask

  task automatic wrMode(input int v);
    modeWrEn = 1'b1; modeWrData = 5'(v);
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  task automatic toggleExt(input int times, input int hold);
    for (int i = 0; i < times; i++) begin
      extStrobe = ~extStrobe;
      cyc(hold);
    end
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    // R1: reset state at the ports
    check("R1 irqOut", int'(irqOut), 0);
    check("R1 bitClkOut", int'(bitClkOut), 0);
    check("R1 wordStrobeOut", int'(wordStrobeOut), 0);
    check("R1 wsStatus", int'(wsStatus), 2);
    running = 1'b1;
    cyc(5);

    // R1 default divider, R6 entering master mode restarts the period
    irqTag = "R1 R6";
    wrMode(5'b00011);
    cyc(1250);

    // R2: divider writes restart the timer, including mid-period and same value
    irqTag = "R2";
    wrDiv(0);
    cyc(200);
    wrDiv(2);
    cyc(100);
    wrDiv(2);
    cyc(500);

    // R3: steady master-mode pulses
    irqTag = "R3";
    wrDiv(1);
    cyc(400);

    // R5: strobe output disabled while still in master mode
    irqTag = "R5";
    wrMode(5'b00001);
    cyc(300);
    wrMode(5'b00011);
    cyc(150);

    // R7: slave, rising edges
    irqTag = "R7";
    wrMode(5'b00100);
    cyc(10);
    toggleExt(8, 15);

    // R8: slave, falling edges
    irqTag = "R8";
    wrMode(5'b01000);
    toggleExt(8, 12);
    wrMode(5'b01100);
    toggleExt(6, 5);

    // R9: every word, slow and fast toggles
    irqTag = "R9";
    wrMode(5'b10000);
    toggleExt(6, 9);
    toggleExt(10, 1);
    toggleExt(10, 2);
    cyc(6);

    // R10: no edge selected
    irqTag = "R10";
    wrMode(5'b00000);
    toggleExt(10, 3);
    toggleExt(6, 1);
    cyc(6);

    // back to master mode from slave: R6 again
    irqTag = "R6";
    wrDiv(0);
    wrMode(5'b00011);
    cyc(300);

    running = 1'b0;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule